// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Fast Line

This block collects up to 32 raw interrupt inputs and presents them to a processor on two request lines: a normal request line that carries a vector lookup, and a fast request line that does not. Thirty-two priority levels sit between the inputs and the lines. Each level has a configuration word and a vector word, both reached over a simple single-cycle register bus. The configuration word picks the raw input that feeds the level and can invert it. It also chooses the line the level drives and turns the level on.

Among the enabled, active levels routed to the normal line, level 0 has the highest priority and level 31 the lowest. The winning level's vector and number are registered every cycle and can be read back. A read of the vector register acknowledges the request, which moves the service state machine from `ST_IDLE` to `ST_SERVICE`. In `ST_SERVICE` the acknowledged level and every level below it in priority are held off, and the vector and number registers stay frozen. A write to the end-of-service register moves the machine from `ST_SERVICE` back to `ST_IDLE`. Only level 0 may drive the fast line. Its request goes straight to the output, one cycle later, and the vector words play no part in it.

Top module: `vic_top`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, every configuration word and vector word reads 0, and the vector register (address 0x40) and level register (address 0x41) read 0.
- R2: Configuration words are at addresses 0x00 to 0x1F, one per level, and vector words are at 0x20 to 0x3F. In a configuration word, bits [4:0] select the raw input, bit 8 inverts it, bit 9 routes the level to the fast line and bit 10 enables the level. Other bits read back as 0. Vector words keep all 32 bits.
- R3: A level with bit 10 clear never raises `irq_o` or `fiq_o`, whatever its input does.
- R4: A level is active when `src_i[sel]` XOR its invert bit is 1. Inputs are level-sensitive.
- R5: One cycle after the inputs or configuration change, `irq_o` is high exactly when some enabled, active level with bit 9 clear is eligible. The lowest-numbered such level wins. While idle, address 0x40 reads its vector word and 0x41 reads its number. Both read 0 when no level wins.
- R6: `fiq_o` is high one cycle after level 0 is enabled, routed to the fast line and active. A fast-routed level 0 takes no part in normal-line resolution. A level above 0 with bit 9 set is treated as disabled.
- R7: A read of 0x40 while idle with `irq_o` high acknowledges the request. It latches the level just read and freezes addresses 0x40 and 0x41. Until end of service, only levels numbered below the latched one can raise `irq_o`. `fiq_o` is unaffected.
- R8: A write of any data to address 0x42 during service returns the block to idle. The vector and level registers track the winner again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw level-sensitive interrupt inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (a read of 0x40 acknowledges) |
| bus_addr_i | input | 7 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request, registered, active high |
| fiq_o | output | 1 | Fast interrupt request, registered, active high |

## Verification
A wrong configuration field or a bad priority pick shows on `irq_o`, `fiq_o` or the level register one cycle after the stimulus. The bench compares both lines with a behavioural model at every clock. A service state machine stuck in `ST_SERVICE` holds the level register frozen and keeps lower levels silent, which shows at the first level read after an end-of-service write. A wrong latched level shows as a level that should be masked raising `irq_o`, or one that should not be masked staying quiet, within a cycle of its input changing.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int SRC_COUNT = 32;
    localparam int SEL_W     = $clog2(SRC_COUNT);

    // configuration word bit positions (software visible)
    localparam int CFG_INV_BIT  = 8;
    localparam int CFG_FAST_BIT = 9;
    localparam int CFG_EN_BIT   = 10;

    typedef struct packed {
        logic             en;
        logic             fast;
        logic             inv;
        logic [SEL_W-1:0] sel;
    } lvl_cfg_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

    function automatic lvl_cfg_t word_to_cfg(input logic [31:0] w);
        lvl_cfg_t c;
        c.sel  = w[SEL_W-1:0];
        c.inv  = w[CFG_INV_BIT];
        c.fast = w[CFG_FAST_BIT];
        c.en   = w[CFG_EN_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input lvl_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[SEL_W-1:0]   = c.sel;
        w[CFG_INV_BIT] = c.inv;
        w[CFG_FAST_BIT] = c.fast;
        w[CFG_EN_BIT]  = c.en;
        return w;
    endfunction
endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 7,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output lvl_cfg_t          cfg_o [NUM_LEVELS],
    output logic [DATA_W-1:0] vec_o [NUM_LEVELS]
);
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(NUM_LEVELS);
    localparam logic [ADDR_W-1:0] VEC_END = ADDR_W'(2 * NUM_LEVELS);

    logic [LVL_W-1:0] idx;
    logic             hit_cfg;
    logic             hit_vec;

    assign idx     = addr[LVL_W-1:0];
    assign hit_cfg = wr_en && (addr < CFG_END);
    assign hit_vec = wr_en && (addr >= CFG_END) && (addr < VEC_END);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
                vec_o[g] <= '0;
            end else begin
                if (hit_cfg && idx == LVL_W'(g))
                    cfg_o[g] <= word_to_cfg(32'(wdata));
                if (hit_vec && idx == LVL_W'(g))
                    vec_o[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/vic_src_sel.sv
module vic_src_sel
    import vic_pkg::*;
#(
    parameter int NUM_LEVELS = 32
) (
    input  logic [SRC_COUNT-1:0]  src_i,
    input  lvl_cfg_t              cfg_i [NUM_LEVELS],
    output logic [NUM_LEVELS-1:0] irq_act_o,
    output logic                  fiq_act_o
);
    logic [NUM_LEVELS-1:0] raw;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        assign raw[g]       = src_i[cfg_i[g].sel] ^ cfg_i[g].inv;
        // a fast-routed level never competes on the normal line
        assign irq_act_o[g] = cfg_i[g].en && !cfg_i[g].fast && raw[g];
        if (g == 0) begin : g_fast
            assign fiq_act_o = cfg_i[g].en && cfg_i[g].fast && raw[g];
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NUM_LEVELS = 32,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] req_i,
    output logic                  win_valid_o,
    output logic [LVL_W-1:0]      win_lvl_o
);
    always_comb begin
        win_valid_o = 1'b0;
        win_lvl_o   = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                win_valid_o = 1'b1;
                win_lvl_o   = LVL_W'(i);
            end
        end
    end

    // R5
    win_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> req_i[win_lvl_o]);

    // R5
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> !win_valid_o);
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o,
    output logic                 fiq_o
);
    localparam int LVL_W = $clog2(NUM_LEVELS);
    localparam logic [ADDR_W-1:0] CFG_END   = ADDR_W'(NUM_LEVELS);
    localparam logic [ADDR_W-1:0] VEC_END   = ADDR_W'(2 * NUM_LEVELS);
    localparam logic [ADDR_W-1:0] VECT_ADDR = ADDR_W'(2 * NUM_LEVELS);
    localparam logic [ADDR_W-1:0] LVL_ADDR  = ADDR_W'(2 * NUM_LEVELS + 1);
    localparam logic [ADDR_W-1:0] EOI_ADDR  = ADDR_W'(2 * NUM_LEVELS + 2);

    lvl_cfg_t              cfg_q [NUM_LEVELS];
    logic [DATA_W-1:0]     vec_q [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] irq_act;
    logic                  fiq_act;
    logic [NUM_LEVELS-1:0] allow;
    logic [NUM_LEVELS-1:0] eligible;
    logic                  win_valid;
    logic [LVL_W-1:0]      win_lvl;

    svc_state_e        st_q, st_d;
    logic [LVL_W-1:0]  svc_lvl_q;
    logic [LVL_W-1:0]  cur_lvl_q;
    logic [DATA_W-1:0] cur_vec_q;
    logic              ack;
    logic              eoi;

    vic_cfg_regs #(
        .NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .cfg_o(cfg_q), .vec_o(vec_q)
    );

    vic_src_sel #(.NUM_LEVELS(NUM_LEVELS)) u_sel (
        .src_i(src_i), .cfg_i(cfg_q), .irq_act_o(irq_act), .fiq_act_o(fiq_act)
    );

    // during service only levels of higher priority than the latched one pass
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_allow
        assign allow[g] = (st_q == ST_IDLE) || (LVL_W'(g) < svc_lvl_q);
    end
    assign eligible = irq_act & allow;

    vic_prio #(.NUM_LEVELS(NUM_LEVELS)) u_prio (
        .clk(clk), .rst_n(rst_n), .req_i(eligible),
        .win_valid_o(win_valid), .win_lvl_o(win_lvl)
    );

    assign ack = (st_q == ST_IDLE) && bus_rd_i && (bus_addr_i == VECT_ADDR) && irq_o;
    assign eoi = (st_q == ST_SERVICE) && bus_wr_i && (bus_addr_i == EOI_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (ack) st_d = ST_SERVICE;
            ST_SERVICE: if (eoi) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            fiq_o     <= 1'b0;
            svc_lvl_q <= '0;
            cur_lvl_q <= '0;
            cur_vec_q <= '0;
        end else begin
            irq_o <= win_valid;
            fiq_o <= fiq_act;
            if (ack)
                svc_lvl_q <= cur_lvl_q;
            if (st_q == ST_IDLE && !ack) begin
                cur_lvl_q <= win_valid ? win_lvl : '0;
                cur_vec_q <= win_valid ? vec_q[win_lvl] : '0;
            end
        end
    end

    // read data
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i < CFG_END)
            bus_rdata_o = DATA_W'(cfg_to_word(cfg_q[bus_addr_i[LVL_W-1:0]]));
        else if (bus_addr_i < VEC_END)
            bus_rdata_o = vec_q[bus_addr_i[LVL_W-1:0]];
        else if (bus_addr_i == VECT_ADDR)
            bus_rdata_o = cur_vec_q;
        else if (bus_addr_i == LVL_ADDR)
            bus_rdata_o = DATA_W'(cur_lvl_q);
    end

    // R6
    fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(cfg_q[0].en && cfg_q[0].fast));

    // R7
    ack_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_SERVICE) |-> (svc_lvl_q == $past(cur_lvl_q)));

    // R7
    frozen_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SERVICE && $past(st_q == ST_SERVICE)) |->
            ($stable(cur_lvl_q) && $stable(cur_vec_q)));

    // R8
    eoi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> (st_q == ST_IDLE));
endmodule

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // behavioural reference model
    int          m_cfg [32];
    int unsigned m_vec [32];
    bit          m_svc;
    int          m_svc_lvl, m_lvl;
    int unsigned m_vecout;
    bit          m_irq, m_fiq;

    function automatic bit lvl_on(int i);
        bit r;
        r = src[m_cfg[i] & 31] ^ m_cfg[i][8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cfg[i]) begin m_cfg[i] = 0; m_vec[i] = 0; end
            m_svc = 0; m_svc_lvl = 0; m_lvl = 0; m_vecout = 0; m_irq = 0; m_fiq = 0;
        end else begin
            int  w;
            bit  ack, eoi, was_svc;
            w = -1;
            for (int i = 31; i >= 0; i--)
                if (m_cfg[i][10] && !m_cfg[i][9] && lvl_on(i) && (!m_svc || i < m_svc_lvl))
                    w = i;
            was_svc = m_svc;
            ack = !was_svc && rd && addr == 7'h40 && m_irq;
            eoi = was_svc && wr && addr == 7'h42;
            m_fiq = m_cfg[0][10] && m_cfg[0][9] && lvl_on(0);
            m_irq = (w >= 0);
            if (ack) begin m_svc = 1; m_svc_lvl = m_lvl; end
            else if (eoi) m_svc = 0;
            if (!was_svc && !ack) begin
                m_lvl    = (w >= 0) ? w : 0;
                m_vecout = (w >= 0) ? m_vec[w] : 0;
            end
            if (wr && addr < 7'h20) m_cfg[addr] = int'(wdata & 32'h0000_071F);
            else if (wr && addr < 7'h40) m_vec[addr - 7'h20] = wdata;
        end
    end

    // compare the request lines with the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (irq !== m_irq || fiq !== m_fiq) begin
                fails++;
                $display("FAIL R5 R6 model: irq=%0b fiq=%0b expected irq=%0b fiq=%0b",
                         irq, fiq, m_irq, m_fiq);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [6:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1;
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", req, a, rdata, exp);
        end
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic check_line(input logic act, input logic exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: line got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_line(irq, 1'b0, "R1 irq");
        check_line(fiq, 1'b0, "R1 fiq");
        bus_rd(7'h05, 32'h0, "R1 cfg");
        bus_rd(7'h25, 32'h0, "R1 vec");
        bus_rd(7'h40, 32'h0, "R1 vect");
        bus_rd(7'h41, 32'h0, "R1 level");

        // R2 field layout and read-back
        bus_wr(7'h0A, 32'hFFFF_FFFF);
        bus_rd(7'h0A, 32'h0000_071F, "R2 cfg mask");
        bus_wr(7'h0A, 32'h0);
        bus_wr(7'h2A, 32'hDEAD_BEEF);
        bus_rd(7'h2A, 32'hDEAD_BEEF, "R2 vec");

        // R3 disabled level ignored
        bus_wr(7'h02, 32'h0000_0007);
        bus_wr(7'h22, 32'h0000_0200);
        src = 32'h0000_0080;
        idle(2);
        check_line(irq, 1'b0, "R3 disabled irq");
        bus_rd(7'h41, 32'h0, "R3 level");

        // R5 single level wins
        bus_wr(7'h23, 32'h1000_0300);
        bus_wr(7'h03, 32'h0000_0407);
        idle(2);
        check_line(irq, 1'b1, "R5 irq");
        bus_rd(7'h41, 32'd3, "R5 level");

        // R4 inverted source on a higher level
        bus_wr(7'h21, 32'h1000_0100);
        bus_wr(7'h01, 32'h0000_0509);
        idle(2);
        bus_rd(7'h41, 32'd1, "R4 inverted low active");
        src[9] = 1'b1;
        idle(2);
        bus_rd(7'h41, 32'd3, "R4 inverted high inactive");

        // R7 acknowledge and service masking
        bus_rd(7'h40, 32'h1000_0300, "R7 ack vector");
        idle(2);
        check_line(irq, 1'b0, "R7 acked level masked");
        src[9] = 1'b0;
        idle(2);
        check_line(irq, 1'b1, "R7 higher level passes");
        bus_rd(7'h41, 32'd3, "R7 level frozen");
        bus_rd(7'h40, 32'h1000_0300, "R7 vector frozen");

        // R8 end of service
        bus_wr(7'h42, 32'h0);
        idle(2);
        bus_rd(7'h41, 32'd1, "R8 tracking again");
        bus_rd(7'h40, 32'h1000_0100, "R8 ack level 1");
        bus_wr(7'h42, 32'h1234_5678);
        idle(2);

        // R6 fast line
        bus_wr(7'h00, 32'h0000_060C);
        src[12] = 1'b1;
        idle(2);
        check_line(fiq, 1'b1, "R6 fiq high");
        bus_rd(7'h41, 32'd1, "R6 level 0 not on irq");
        bus_wr(7'h25, 32'h0000_0555);
        bus_wr(7'h05, 32'h0000_060C);
        bus_wr(7'h01, 32'h0);
        bus_wr(7'h03, 32'h0);
        idle(2);
        check_line(irq, 1'b0, "R6 fast bit above level 0 disables");
        bus_rd(7'h40, 32'h0, "R6 no vector");

        // R3 disabling level 0 drops fast line
        bus_wr(7'h00, 32'h0000_020C);
        idle(2);
        check_line(fiq, 1'b0, "R3 fiq disabled");

        idle(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule